// File: doc/BRIEF.md
# Memory Pattern Test Agent

The agent exercises a region of memory with a generated data pattern and reports which data bits ever miscompared. Software or a sequencer supplies a base address, a region length, a pattern choice, an operation mode and a loop exponent, then pulses a start input. The agent issues one request per cycle on a simple request interface. It accepts read data on a valid strobe, in request order and after any latency. It folds every difference between returned and expected data into a per-bit error mask.

Two flows exist. In write-then-read mode the agent first writes the whole sequence. When that phase completes it stops writing, restarts the pattern and reads the same sequence back with compare. In read-check mode it only reads and compares against the pattern, so it never writes. The result is complete when the done flag rises: a zero mask means pass, and each set bit names a failing data bit. An unusable configuration is refused at start and flagged.

Top module: `mem_pattern_agent`

## Requirements
- R1: While and after reset, with no start, `mem_req_o`, `busy_o`, `done_o` and `cfg_err_o` are 0 and `err_mask_o` is all zeros.
- R2: A start seen while idle with `log2_loop_i` above 15 or `pat_sel_i` = 2'b11 sets `cfg_err_o` and clears `done_o` the next cycle, and issues no request; `busy_o` stays 0. A start accepted with a valid configuration clears `cfg_err_o`.
- R3: Transfer i of a phase (i from 0) targets `base_addr_i + (i mod len_i)`; `len_i` of 0 acts as 1.
- R4: With `mode_i` = 1 (write-then-read), N writes (`mem_we_o` = 1) are issued on consecutive cycles from the cycle after start, followed at once by N reads of the same addresses. With `mode_i` = 0 (read-check), only the N reads are issued and `mem_we_o` is never 1.
- R5: `pat_sel_i` = 2'b00: word i is the state after i steps of a 32-bit register seeded with 1, where each step is a left shift that XORs in 32'h0040_0007 when the bit shifted out was 1. The word is repeated over the data width.
- R6: `pat_sel_i` = 2'b01: byte b_i = (0x11 + 13*i) mod 256 is repeated in every byte lane, and the whole word is inverted when i is odd.
- R7: `pat_sel_i` = 2'b10: word 2k is a single 1 at bit (k mod DW) and word 2k+1 is its bitwise complement.
- R8: When done, `err_mask_o` is the OR over all N reads of (returned data XOR expected word i), where responses are matched to reads in issue order.
- R9: `busy_o` is 1 from the cycle after an accepted start until the cycle after the N-th read response, and `done_o` rises in that same cycle. `done_o` then holds until the next accepted or rejected start. `busy_o` and `done_o` are never both 1.
- R10: A start pulse while busy is ignored, and the running test's requests and result are unaffected.
- R11: A phase has exactly N = 2^`log2_loop_i` transfers, for every exponent from 0 to 15 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | 1 = write-then-read, 0 = read-check only |
| pat_sel_i | input | 2 | Pattern: 00 LFSR, 01 incrementing byte, 10 walking crosstalk |
| log2_loop_i | input | LW | Transfer count exponent |
| base_addr_i | input | AW | First address of the region |
| len_i | input | AW | Region length in words |
| mem_req_o | output | 1 | Request valid (accepted every cycle) |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Request address |
| mem_wdata_o | output | DW | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| busy_o | output | 1 | Test running |
| done_o | output | 1 | Compare complete, mask valid |
| cfg_err_o | output | 1 | Last start rejected |
| err_mask_o | output | DW | Per-bit compare error mask |

## Verification
The assertions assume that the memory side accepts every request in the cycle it is issued. They also assume that it returns exactly one response per read, in order, and never a response without a read. The bench memory answers each read one cycle later with the stored word, optionally XORed with a chosen flip mask at one address. It never answers anything else, so all response timing stays inside that contract. Starts are pulsed for a single cycle, except for the deliberate mid-run pulse used to show that a start while busy is ignored.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

  typedef enum logic [1:0] {
    PAT_ISI = 2'b00,
    PAT_AUD = 2'b01,
    PAT_XT  = 2'b10,
    PAT_RSV = 2'b11
  } pat_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_WAIT
  } state_e;

  localparam logic [31:0] LFSR_SEED = 32'h0000_0001;
  localparam logic [31:0] LFSR_TAPS = 32'h0040_0007;
  localparam logic [7:0]  AUD_INIT  = 8'h11;
  localparam logic [7:0]  AUD_STEP  = 8'h0D;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? LFSR_TAPS : 32'h0);
  endfunction

endpackage

// File: rtl/tpa_pat_gen.sv
module tpa_pat_gen
  import tpa_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  pat_e          sel_i,
  output logic [DW-1:0] data_o
);

  localparam int PW = (DW > 1) ? $clog2(DW) : 1;

  logic          odd_q;
  logic [31:0]   lfsr_q;
  logic [7:0]    aud_q;
  logic [PW-1:0] pos_q;
  logic [DW-1:0] isi_w, aud_w, xt_w;

  // all three sequences step together; only the selected one is observed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= 1'b0;
      lfsr_q <= LFSR_SEED;
      aud_q  <= AUD_INIT;
      pos_q  <= '0;
    end else if (load_i) begin
      odd_q  <= 1'b0;
      lfsr_q <= LFSR_SEED;
      aud_q  <= AUD_INIT;
      pos_q  <= '0;
    end else if (adv_i) begin
      odd_q  <= ~odd_q;
      lfsr_q <= lfsr_next(lfsr_q);
      aud_q  <= aud_q + AUD_STEP;
      if (odd_q) pos_q <= (pos_q == PW'(DW - 1)) ? '0 : pos_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DW; g++) begin : g_lane
    assign isi_w[g] = lfsr_q[g % 32];
    assign aud_w[g] = aud_q[g % 8];
  end

  assign xt_w = DW'(1) << pos_q;

  always_comb begin
    unique case (sel_i)
      PAT_AUD: data_o = aud_w ^ {DW{odd_q}};
      PAT_XT:  data_o = xt_w ^ {DW{odd_q}};
      default: data_o = isi_w;
    endcase
  end

endmodule

// File: rtl/tpa_addr_walk.sv
module tpa_addr_walk #(
  parameter int AW = 16,
  parameter int CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic [CW-1:0] nmax_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  logic [AW-1:0] off_q;
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (len_i <= AW'(1)) || (off_q == len_i - AW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      off_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      off_q <= wrap ? '0 : off_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign addr_o = base_i + off_q;
  assign last_o = (cnt_q == nmax_i);

endmodule

// File: rtl/mem_pattern_agent.sv
module mem_pattern_agent
  import tpa_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int LW       = 5,
  parameter int MAX_LOG2 = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [1:0]    pat_sel_i,
  input  logic [LW-1:0] log2_loop_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [AW-1:0] len_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          cfg_err_o,
  output logic [DW-1:0] err_mask_o
);

  localparam int CW = MAX_LOG2;

  state_e        state_q, state_d;
  pat_e          sel_q;
  logic [AW-1:0] base_q, len_q;
  logic [CW-1:0] nmax_q, nmax_d, rcv_cnt_q;
  logic [DW-1:0] err_q, exp_data;
  logic          done_q, cfg_err_q;
  logic          accept, cfg_ok, go;
  logic          iss_clr, iss_last, rsp, rcv_last;

  assign accept = start_i && (state_q == ST_IDLE);
  assign cfg_ok = (log2_loop_i <= LW'(MAX_LOG2)) && (pat_sel_i != 2'b11);
  assign go     = accept && cfg_ok;
  // 2^L - 1 modulo 2^CW, exact for every accepted exponent
  assign nmax_d = CW'(32'd1 << log2_loop_i) - CW'(1);

  assign mem_req_o = (state_q == ST_WR) || (state_q == ST_RD);
  assign mem_we_o  = (state_q == ST_WR);
  assign rsp       = mem_rvalid_i && ((state_q == ST_RD) || (state_q == ST_WAIT));
  assign rcv_last  = (rcv_cnt_q == nmax_q);
  assign iss_clr   = go || ((state_q == ST_WR) && iss_last);

  tpa_addr_walk #(.AW(AW), .CW(CW)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (iss_clr),
    .step_i (mem_req_o),
    .base_i (base_q),
    .len_i  (len_q),
    .nmax_i (nmax_q),
    .addr_o (mem_addr_o),
    .last_o (iss_last)
  );

  tpa_pat_gen #(.DW(DW)) u_iss_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (iss_clr),
    .adv_i  (mem_req_o),
    .sel_i  (sel_q),
    .data_o (mem_wdata_o)
  );

  // second copy tracks the response stream, which lags the requests
  tpa_pat_gen #(.DW(DW)) u_cmp_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .adv_i  (rsp),
    .sel_i  (sel_q),
    .data_o (exp_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = mode_i ? ST_WR : ST_RD;
      ST_WR:   if (iss_last) state_d = ST_RD;
      ST_RD: begin
        if (rsp && rcv_last) state_d = ST_IDLE;
        else if (iss_last)   state_d = ST_WAIT;
      end
      ST_WAIT: if (rsp && rcv_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sel_q     <= PAT_ISI;
      base_q    <= '0;
      len_q     <= '0;
      nmax_q    <= '0;
      rcv_cnt_q <= '0;
      err_q     <= '0;
      done_q    <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cfg_err_q <= ~cfg_ok;
        done_q    <= 1'b0;
      end
      if (go) begin
        sel_q     <= pat_e'(pat_sel_i);
        base_q    <= base_addr_i;
        len_q     <= len_i;
        nmax_q    <= nmax_d;
        rcv_cnt_q <= '0;
        err_q     <= '0;
      end else if (rsp) begin
        err_q     <= err_q | (mem_rdata_i ^ exp_data);
        rcv_cnt_q <= rcv_cnt_q + 1'b1;
        if (rcv_last) done_q <= 1'b1;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign cfg_err_o  = cfg_err_q;
  assign err_mask_o = err_q;

endmodule

// File: rtl/mem_pattern_agent_chk.sv
module mem_pattern_agent_chk #(
  parameter int AW       = 16,
  parameter int LW       = 5,
  parameter int MAX_LOG2 = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mode_i,
  input logic [1:0]    pat_sel_i,
  input logic [LW-1:0] log2_loop_i,
  input logic [AW-1:0] base_addr_i,
  input logic [AW-1:0] len_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          cfg_err_o
);

  logic          ok_c, take_c, mode_c;
  logic [AW-1:0] base_c, len_c, lim_c, off_c;

  assign ok_c   = (log2_loop_i <= LW'(MAX_LOG2)) && (pat_sel_i != 2'b11);
  assign take_c = start_i && !busy_o && ok_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_c <= 1'b0;
      base_c <= '0;
      len_c  <= '0;
    end else if (take_c) begin
      mode_c <= mode_i;
      base_c <= base_addr_i;
      len_c  <= len_i;
    end
  end

  assign lim_c = (len_c == '0) ? AW'(1) : len_c;
  assign off_c = mem_addr_o - base_c;

  assert_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !ok_c) |=> (cfg_err_o && !busy_o && !done_o && !mem_req_o));

  assert_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_c |=> (busy_o && !done_o && !cfg_err_o));

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mode_c) |-> !mem_we_o);

  assert_addr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (off_c < lim_c));

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind mem_pattern_agent mem_pattern_agent_chk #(
  .AW(AW), .LW(LW), .MAX_LOG2(MAX_LOG2)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .pat_sel_i   (pat_sel_i),
  .log2_loop_i (log2_loop_i),
  .base_addr_i (base_addr_i),
  .len_i       (len_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_mem_pattern_agent.sv
module tb_mem_pattern_agent;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [1:0]    pat_sel_i = 2'b00;
  logic [LW-1:0] log2_loop_i = '0;
  logic [AW-1:0] base_addr_i = '0;
  logic [AW-1:0] len_i = '0;
  logic          mem_req_o, mem_we_o, mem_rvalid_i;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i, err_mask_o;
  logic          busy_o, done_o, cfg_err_o;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  logic [31:0] mem    [256];
  logic [31:0] shadow [256];
  logic [7:0]  f_addr = 8'h00;
  logic [31:0] f_flip = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_pattern_agent #(.DW(DW), .AW(AW), .LW(LW), .MAX_LOG2(15)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .pat_sel_i(pat_sel_i), .log2_loop_i(log2_loop_i), .base_addr_i(base_addr_i),
    .len_i(len_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .cfg_err_o(cfg_err_o), .err_mask_o(err_mask_o)
  );

  // behavioural memory: one-cycle read latency, optional bit flip at one address
  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'h0;
      shadow[i] = 32'h0;
    end
    mem_rvalid_i = 1'b0;
    mem_rdata_i = '0;
  end

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (mem_req_o && !mem_we_o) begin
      mem_rvalid_i <= 1'b1;
      mem_rdata_i  <= mem[mem_addr_o[7:0]] ^ ((mem_addr_o[7:0] == f_addr) ? f_flip : 32'h0);
    end
    if (mem_req_o && mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %h exp %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] step32(input logic [31:0] s);
    logic [31:0] r;
    r = s << 1;
    if (s[31]) r = r ^ 32'h0040_0007;
    return r;
  endfunction

  task automatic run(input bit wr, input logic [1:0] sel, input int l2,
                     input logic [15:0] base, input logic [15:0] len, input bit poke);
    logic [31:0] pat[$];
    logic [31:0] s, w, expm;
    logic [7:0]  a, b;
    string       dtag;
    int n, r, ln, k;
    bit is_wr;
    n  = 1 << l2;
    r  = wr ? 2 * n : n;
    ln = (len == 0) ? 1 : int'(len);
    s  = 32'h1;
    for (int i = 0; i < n; i++) begin
      case (sel)
        2'b00: begin w = s; s = step32(s); end
        2'b01: begin b = 8'(17 + 13 * i); w = {4{b}}; if (i % 2) w = ~w; end
        default: begin w = 32'h1 << ((i / 2) % 32); if (i % 2) w = ~w; end
      endcase
      pat.push_back(w);
    end
    if (wr) for (int j = 0; j < n; j++) shadow[8'(int'(base) + j % ln)] = pat[j];
    expm = 32'h0;
    for (int j = 0; j < n; j++) begin
      a = 8'(int'(base) + j % ln);
      expm = expm | (shadow[a] ^ ((a == f_addr) ? f_flip : 32'h0) ^ pat[j]);
    end
    dtag = (sel == 2'b00) ? "R5" : (sel == 2'b01) ? "R6" : "R7";

    @(negedge clk);
    mode_i = wr; pat_sel_i = sel; log2_loop_i = LW'(l2);
    base_addr_i = base; len_i = len; start_i = 1'b1;
    for (int t = 0; t <= r + 2; t++) begin
      @(negedge clk);
      if (t == 0) start_i = 1'b0;
      chk("R11", "req", {31'b0, mem_req_o}, {31'b0, (t < r)});
      if (t < r) begin
        is_wr = wr && (t < n);
        k = wr ? ((t < n) ? t : t - n) : t;
        chk("R4", "we", {31'b0, mem_we_o}, {31'b0, is_wr});
        chk("R3", "addr", {16'b0, mem_addr_o}, 32'(int'(base) + k % ln));
        if (is_wr) chk(dtag, "wdata", mem_wdata_o, pat[k]);
      end
      chk("R9", "busy", {31'b0, busy_o}, {31'b0, (t <= r)});
      chk("R9", "done", {31'b0, done_o}, {31'b0, (t > r)});
      chk("R2", "cfg_err", {31'b0, cfg_err_o}, 32'h0);
      if (t > r) chk("R8", "mask", err_mask_o, expm);
      // R10: mid-run start with a different setup must be ignored
      if (poke && t == 2) begin
        start_i = 1'b1; mode_i = ~wr; pat_sel_i = 2'b10; base_addr_i = 16'h00F0;
        log2_loop_i = 5'd1;
      end
      if (poke && t == 3) start_i = 1'b0;
    end
    if (poke) chk("R10", "mask after poke", err_mask_o, expm);
  endtask

  task automatic reject(input int l2, input logic [1:0] sel);
    @(negedge clk);
    mode_i = 1'b1; pat_sel_i = sel; log2_loop_i = LW'(l2);
    base_addr_i = 16'h0010; len_i = 16'd4; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 3; t++) begin
      chk("R2", "cfg_err", {31'b0, cfg_err_o}, 32'h1);
      chk("R2", "busy", {31'b0, busy_o}, 32'h0);
      chk("R2", "done", {31'b0, done_o}, 32'h0);
      chk("R2", "req", {31'b0, mem_req_o}, 32'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "req in reset", {31'b0, mem_req_o}, 32'h0);
    chk("R1", "busy in reset", {31'b0, busy_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "req", {31'b0, mem_req_o}, 32'h0);
    chk("R1", "busy", {31'b0, busy_o}, 32'h0);
    chk("R1", "done", {31'b0, done_o}, 32'h0);
    chk("R1", "cfg_err", {31'b0, cfg_err_o}, 32'h0);
    chk("R1", "mask", err_mask_o, 32'h0);

    run(1'b1, 2'b00, 3, 16'h0010, 16'd8, 1'b0);
    run(1'b1, 2'b01, 4, 16'h0040, 16'd16, 1'b1);
    run(1'b1, 2'b10, 7, 16'h0080, 16'd128, 1'b0);
    f_addr = 8'h12; f_flip = 32'h0000_0100;
    run(1'b1, 2'b00, 3, 16'h0010, 16'd8, 1'b0);
    chk("R8", "single flipped bit", err_mask_o, 32'h0000_0100);
    f_flip = 32'h0;
    run(1'b0, 2'b00, 3, 16'h0010, 16'd8, 1'b0);
    run(1'b0, 2'b10, 2, 16'h0010, 16'd8, 1'b0);
    run(1'b1, 2'b01, 4, 16'h0020, 16'd4, 1'b0);
    run(1'b1, 2'b00, 2, 16'h0005, 16'd0, 1'b0);
    run(1'b1, 2'b10, 0, 16'h0030, 16'd3, 1'b0);
    reject(16, 2'b00);
    reject(3, 2'b11);
    reject(31, 2'b01);
    run(1'b0, 2'b00, 15, 16'h0000, 16'd8, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog run did not complete act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule